// File: doc/BRIEF.md
# Audio Serial Port Control and Status Registers

This block is the register file of an audio serial port. It holds one control word and one status word on a simple synchronous bus with address, write strobe, write data and registered read data. Each word has three write addresses. The base address replaces the word. Base + 0x4 ORs the written data into the word. Base + 0x8 clears the bits that are 1 in the written data. Software can therefore change one bit without reading the word first. All three addresses return the same read value.

The control word drives the serial engine's settings as plain outputs: soft reset, clock gate, run, slave mode, receive mode, frame delay, right justification, bit-clock edge, word-clock inversion, word-length code, master-clock divider, 384x base, wide bit clock, and error interrupt enable. The status word reports the engine's busy line and two sticky FIFO error flags. The flags are set by hardware event pulses and are cleared only through the status clear alias. A registered interrupt goes high when the error interrupt enable is on and either flag is set. The serial datapath is not part of this block.

Top module: `sap_ctl_regs`

## Requirements
- R1: After reset the control word reads 0xC000_0000 (bit 31 soft reset and bit 30 clock gate set, all else 0), both error flags read 0 and `irq` is 0.
- R2: A write to the control base (0x00) replaces the implemented bits with the write data. Implemented bits are 0..6, 8..9, 12..16, 20, 30 and 31. Every other bit always reads 0.
- R3: A write to base + 0x4 (control 0x04) sets the written 1 bits and leaves all other bits unchanged.
- R4: A write to base + 0x8 (control 0x08) clears the written 1 bits and leaves all other bits unchanged.
- R5: When a control write leaves bit 31 at 1, every control bit other than 31 and 30 is stored as 0.
- R6: Each control output equals its bit from the clock edge that stores the write onward. The bits are: run 0, slave 1, receive 2, frame delay 3, right justify 4, falling bit-clock 5, word-clock invert 6, word length [9:8], master-clock divider [14:12], 384x base 15, wide bit clock 16, error interrupt enable 20, clock gate 30, soft reset 31.
- R7: The status word (0x10) shows `hw_busy` in bit 0, the underflow flag in bit 4 and the overflow flag in bit 5. A one-cycle event pulse sets its flag, and the flag stays set until a write to 0x18 has a 1 in that flag's bit.
- R8: Writes to 0x10 and 0x14 change neither flag, and software cannot alter the busy bit.
- R9: If an event pulse and a clear of the same flag happen in the same cycle, the flag ends up set.
- R10: `irq` is 1 in the cycle after a cycle in which the error interrupt enable and at least one flag were both 1, and is 0 otherwise.
- R11: Offset 0xC of either word reads 0 and ignores writes.
- R12: `bus_rdata` shows the addressed word as it stood before the clock edge at which the address was presented, valid from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_busy | input | 1 | Engine busy indication |
| evt_underflow | input | 1 | FIFO underflow event pulse |
| evt_overflow | input | 1 | FIFO overflow event pulse |
| ctl_soft_reset | output | 1 | Soft reset |
| ctl_clk_gate | output | 1 | Clock gate |
| ctl_run | output | 1 | Run enable |
| ctl_slave | output | 1 | Take clocks from another port |
| ctl_rx_mode | output | 1 | Receive direction |
| ctl_frame_delay | output | 1 | One bit-clock data delay after frame edge |
| ctl_right_just | output | 1 | Right-justified data |
| ctl_bclk_fall | output | 1 | Launch data on falling bit clock |
| ctl_lr_invert | output | 1 | Invert word-clock polarity |
| ctl_word_len | output | 2 | Word length code |
| ctl_mclk_div | output | 3 | Master-clock divider code |
| ctl_base_384 | output | 1 | 384x base clock instead of 512x |
| ctl_bclk_wide | output | 1 | Wide bit-clock for long words |
| ctl_err_irq_en | output | 1 | FIFO error interrupt enable |
| irq | output | 1 | FIFO error interrupt |

## Verification
The three write forms are swept with a walking one and a walking zero over all 32 bits, and the sweep is repeated for each alias. A walking one exposes a stuck or wrongly placed bit and an unimplemented bit that reads back. A walking zero exposes an alias that also touches bits other than the addressed ones. Because the sweep starts with soft reset high and later passes through bit 31 again, it also separates a correct hold of the fields from a missing one. The flag tests pulse each event alone, race an event against its clear, and write the status word through the plain and set addresses. Together these tell a sticky flag from a level copy, a clear that wins from one that loses, and a flag software can set from one it cannot.

// File: rtl/sap_regs_pkg.sv
package sap_regs_pkg;
  localparam int DATA_W   = 32;
  localparam int REG_SPAN = 16;
  localparam int OFS_SET  = 4;
  localparam int OFS_CLR  = 8;

  typedef enum logic [1:0] {OP_NONE, OP_WR, OP_SET, OP_CLR} wr_op_e;

  // control bit positions
  localparam int B_RUN     = 0;
  localparam int B_SLAVE   = 1;
  localparam int B_RX      = 2;
  localparam int B_DELAY   = 3;
  localparam int B_RJUST   = 4;
  localparam int B_BFALL   = 5;
  localparam int B_LRINV   = 6;
  localparam int B_WLEN    = 8;
  localparam int WLEN_W    = 2;
  localparam int B_MDIV    = 12;
  localparam int MDIV_W    = 3;
  localparam int B_BASE384 = 15;
  localparam int B_WIDE    = 16;
  localparam int B_IRQEN   = 20;
  localparam int B_GATE    = 30;
  localparam int B_SRST    = 31;

  // status bit positions
  localparam int B_BUSY  = 0;
  localparam int B_UFLAG = 4;
  localparam int B_OFLAG = 5;
  localparam int N_FLAGS = 2;

  function automatic logic [DATA_W-1:0] field_mask(int pos, int width);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < width; i++) m[pos+i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CTRL_KEEP =
    field_mask(B_GATE, 1) | field_mask(B_SRST, 1);
  localparam logic [DATA_W-1:0] CTRL_FIELDS =
    field_mask(B_RUN, 7) | field_mask(B_WLEN, WLEN_W) |
    field_mask(B_MDIV, MDIV_W) | field_mask(B_BASE384, 1) |
    field_mask(B_WIDE, 1) | field_mask(B_IRQEN, 1);
  localparam logic [DATA_W-1:0] CTRL_IMPL    = CTRL_KEEP | CTRL_FIELDS;
  localparam logic [DATA_W-1:0] CTRL_RST_VAL = CTRL_KEEP;

  function automatic logic [DATA_W-1:0] apply_op(wr_op_e op,
                                                 logic [DATA_W-1:0] cur,
                                                 logic [DATA_W-1:0] wd);
    case (op)
      OP_WR:   return wd;
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/sap_addr_decode.sv
module sap_addr_decode
  import sap_regs_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CTRL_BASE = 0,
  parameter int STAT_BASE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output wr_op_e            ctrl_op,
  output wr_op_e            stat_op,
  output logic              ctrl_hit,
  output logic              stat_hit
);
  localparam int OFS_W = $clog2(REG_SPAN);
  localparam int BLK_W = ADDR_W - OFS_W;
  localparam logic [BLK_W-1:0] CTRL_BLK = BLK_W'(CTRL_BASE / REG_SPAN);
  localparam logic [BLK_W-1:0] STAT_BLK = BLK_W'(STAT_BASE / REG_SPAN);

  logic [BLK_W-1:0] blk;
  logic [OFS_W-1:0] ofs;
  wr_op_e           alias_op;
  logic             alias_ok;

  assign blk = addr[ADDR_W-1:OFS_W];
  assign ofs = addr[OFS_W-1:0];

  always_comb begin
    alias_ok = 1'b1;
    alias_op = OP_NONE;
    case (ofs)
      OFS_W'(0):       alias_op = OP_WR;
      OFS_W'(OFS_SET): alias_op = OP_SET;
      OFS_W'(OFS_CLR): alias_op = OP_CLR;
      default:         alias_ok = 1'b0;
    endcase
  end

  assign ctrl_hit = alias_ok && (blk == CTRL_BLK);
  assign stat_hit = alias_ok && (blk == STAT_BLK);
  assign ctrl_op  = (we && ctrl_hit) ? alias_op : OP_NONE;
  assign stat_op  = (we && stat_hit) ? alias_op : OP_NONE;

  // R11: at most one word is written per cycle
  a_r11_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl_op != OP_NONE, stat_op != OP_NONE}));
  // R11: a write strobe with no hit produces no operation
  a_r11_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_hit && !stat_hit) |-> (ctrl_op == OP_NONE && stat_op == OP_NONE));
endmodule

// File: rtl/sap_ctrl_reg.sv
module sap_ctrl_reg
  import sap_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wr_op_e            op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q
);
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    merged = apply_op(op, ctrl_q, wdata) & CTRL_IMPL;
    nxt    = merged[B_SRST] ? (merged & CTRL_KEEP) : merged;
  end

  always_ff @(posedge clk) begin
    if (rst)                ctrl_q <= CTRL_RST_VAL;
    else if (op != OP_NONE) ctrl_q <= nxt;
  end

  // R3: set alias leaves every written field bit at 1 when reset stays off
  a_r3_set_bits: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SET && !wdata[B_SRST] && !ctrl_q[B_SRST]) |=>
      ((ctrl_q & $past(wdata) & CTRL_IMPL) == ($past(wdata) & CTRL_IMPL)));
  // R4: clear alias leaves every written bit at 0
  a_r4_clear_bits: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CLR) |=> ((ctrl_q & $past(wdata)) == '0));
  // R5: while soft reset is held, no field is active
  a_r5_fields_held: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[B_SRST] |-> ((ctrl_q & CTRL_FIELDS) == '0));
  // R2: no bus cycle leaves the word changed when idle
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NONE) |=> $stable(ctrl_q));
endmodule

// File: rtl/sap_err_flags.sv
module sap_err_flags
  import sap_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  wr_op_e             op,
  input  logic [N_FLAGS-1:0] clr_bits,
  input  logic [N_FLAGS-1:0] evt,
  output logic [N_FLAGS-1:0] flag_q
);
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    logic clear_now;
    assign clear_now = (op == OP_CLR) && clr_bits[g];

    always_ff @(posedge clk) begin
      if (rst)            flag_q[g] <= 1'b0;
      else if (evt[g])    flag_q[g] <= 1'b1;
      else if (clear_now) flag_q[g] <= 1'b0;
    end

    // R9: an event always leaves the flag set
    a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
      evt[g] |=> flag_q[g]);
    // R7: a set flag stays set unless cleared through the alias
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      (flag_q[g] && !clear_now) |=> flag_q[g]);
    // R8: a flag rises only on an event
    a_r8_no_sw_set: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_q[g]) |-> $past(evt[g]));
  end
endmodule

// File: rtl/sap_ctl_regs.sv
module sap_ctl_regs
  import sap_regs_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CTRL_BASE = 0,
  parameter int STAT_BASE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hw_busy,
  input  logic              evt_underflow,
  input  logic              evt_overflow,
  output logic              ctl_soft_reset,
  output logic              ctl_clk_gate,
  output logic              ctl_run,
  output logic              ctl_slave,
  output logic              ctl_rx_mode,
  output logic              ctl_frame_delay,
  output logic              ctl_right_just,
  output logic              ctl_bclk_fall,
  output logic              ctl_lr_invert,
  output logic [WLEN_W-1:0] ctl_word_len,
  output logic [MDIV_W-1:0] ctl_mclk_div,
  output logic              ctl_base_384,
  output logic              ctl_bclk_wide,
  output logic              ctl_err_irq_en,
  output logic              irq
);
  wr_op_e             ctrl_op;
  wr_op_e             stat_op;
  logic               ctrl_hit;
  logic               stat_hit;
  logic [DATA_W-1:0]  ctrl_q;
  logic [N_FLAGS-1:0] flag_q;
  logic [DATA_W-1:0]  stat_word;

  sap_addr_decode #(
    .ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE), .STAT_BASE(STAT_BASE)
  ) u_dec (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we),
    .ctrl_op(ctrl_op), .stat_op(stat_op),
    .ctrl_hit(ctrl_hit), .stat_hit(stat_hit)
  );

  sap_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .op(ctrl_op), .wdata(bus_wdata), .ctrl_q(ctrl_q)
  );

  sap_err_flags u_flags (
    .clk(clk), .rst(rst), .op(stat_op),
    .clr_bits({bus_wdata[B_OFLAG], bus_wdata[B_UFLAG]}),
    .evt({evt_overflow, evt_underflow}),
    .flag_q(flag_q)
  );

  always_comb begin
    stat_word          = '0;
    stat_word[B_BUSY]  = hw_busy;
    stat_word[B_UFLAG] = flag_q[0];
    stat_word[B_OFLAG] = flag_q[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= ctrl_hit ? ctrl_q : (stat_hit ? stat_word : '0);
      irq       <= ctrl_q[B_IRQEN] && (|flag_q);
    end
  end

  assign ctl_soft_reset  = ctrl_q[B_SRST];
  assign ctl_clk_gate    = ctrl_q[B_GATE];
  assign ctl_run         = ctrl_q[B_RUN];
  assign ctl_slave       = ctrl_q[B_SLAVE];
  assign ctl_rx_mode     = ctrl_q[B_RX];
  assign ctl_frame_delay = ctrl_q[B_DELAY];
  assign ctl_right_just  = ctrl_q[B_RJUST];
  assign ctl_bclk_fall   = ctrl_q[B_BFALL];
  assign ctl_lr_invert   = ctrl_q[B_LRINV];
  assign ctl_word_len    = ctrl_q[B_WLEN +: WLEN_W];
  assign ctl_mclk_div    = ctrl_q[B_MDIV +: MDIV_W];
  assign ctl_base_384    = ctrl_q[B_BASE384];
  assign ctl_bclk_wide   = ctrl_q[B_WIDE];
  assign ctl_err_irq_en  = ctrl_q[B_IRQEN];

  // R10: interrupt only follows an enabled, pending error
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctl_err_irq_en && (|flag_q)));
  // R10: an enabled, pending error raises the interrupt one cycle later
  a_r10_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (ctl_err_irq_en && (|flag_q)) |=> irq);
  // R11: unmapped offsets read back as zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_hit && !stat_hit) |=> (bus_rdata == '0));
endmodule

// File: tb/sim_sap_ctl_regs.sv
`timescale 1ns/1ps
module sim_sap_ctl_regs;
  import sap_regs_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hw_busy = 1'b0;
  logic        evt_underflow = 1'b0;
  logic        evt_overflow = 1'b0;
  logic        ctl_soft_reset, ctl_clk_gate, ctl_run, ctl_slave, ctl_rx_mode;
  logic        ctl_frame_delay, ctl_right_just, ctl_bclk_fall, ctl_lr_invert;
  logic [1:0]  ctl_word_len;
  logic [2:0]  ctl_mclk_div;
  logic        ctl_base_384, ctl_bclk_wide, ctl_err_irq_en, irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic finished = 1'b0;

  // expected state, from the requirements
  logic [31:0] m_ctrl;
  logic        m_uf, m_of;

  localparam logic [31:0] IMPL = 32'hC011_F37F;

  always #2.5 clk = ~clk;

  sap_ctl_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_busy(hw_busy),
    .evt_underflow(evt_underflow), .evt_overflow(evt_overflow),
    .ctl_soft_reset(ctl_soft_reset), .ctl_clk_gate(ctl_clk_gate),
    .ctl_run(ctl_run), .ctl_slave(ctl_slave), .ctl_rx_mode(ctl_rx_mode),
    .ctl_frame_delay(ctl_frame_delay), .ctl_right_just(ctl_right_just),
    .ctl_bclk_fall(ctl_bclk_fall), .ctl_lr_invert(ctl_lr_invert),
    .ctl_word_len(ctl_word_len), .ctl_mclk_div(ctl_mclk_div),
    .ctl_base_384(ctl_base_384), .ctl_bclk_wide(ctl_bclk_wide),
    .ctl_err_irq_en(ctl_err_irq_en), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_next(int kind, logic [31:0] cur,
                                             logic [31:0] wd);
    logic [31:0] v;
    case (kind)
      0:       v = wd;
      1:       v = cur | wd;
      default: v = cur & ~wd;
    endcase
    v = v & IMPL;
    if (v[31]) v = v & 32'hC000_0000;
    return v;
  endfunction

  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] pack_outputs();
    logic [31:0] v;
    v = '0;
    v[0] = ctl_run; v[1] = ctl_slave; v[2] = ctl_rx_mode;
    v[3] = ctl_frame_delay; v[4] = ctl_right_just; v[5] = ctl_bclk_fall;
    v[6] = ctl_lr_invert; v[9:8] = ctl_word_len; v[14:12] = ctl_mclk_div;
    v[15] = ctl_base_384; v[16] = ctl_bclk_wide; v[20] = ctl_err_irq_en;
    v[30] = ctl_clk_gate; v[31] = ctl_soft_reset;
    return v;
  endfunction

  function automatic logic [31:0] stat_exp();
    logic [31:0] v;
    v = '0;
    v[0] = hw_busy; v[4] = m_uf; v[5] = m_of;
    return v;
  endfunction

  task automatic pulse(logic uf, logic of);
    @(negedge clk);
    evt_underflow = uf; evt_overflow = of;
    @(negedge clk);
    evt_underflow = 1'b0; evt_overflow = 1'b0;
    if (uf) m_uf = 1'b1;
    if (of) m_of = 1'b1;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_ctrl = 32'hC000_0000; m_uf = 1'b0; m_of = 1'b0;

    // R1 reset state
    bus_read(5'h00, rd);  check("R1 ctrl reset", rd, 32'hC000_0000);
    bus_read(5'h10, rd);  check("R1 status reset", rd, 32'h0);
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    check("R1 R6 outputs reset", pack_outputs(), 32'hC000_0000);

    // R2 R3 R4 R5 R6 walking one and walking zero through each write form
    for (int kind = 0; kind < 3; kind++) begin
      for (int pat = 0; pat < 2; pat++) begin
        for (int b = 0; b < 32; b++) begin
          logic [31:0] d;
          logic [4:0]  a;
          d = (pat == 0) ? (32'h1 << b) : ~(32'h1 << b);
          a = (kind == 0) ? 5'h00 : ((kind == 1) ? 5'h04 : 5'h08);
          bus_write(a, d);
          m_ctrl = model_next(kind, m_ctrl, d);
          check("R6 outputs follow word", pack_outputs(), m_ctrl);
          bus_read(5'h00, rd);
          check(kind == 0 ? "R2 R5 plain write" :
                (kind == 1 ? "R3 R5 set alias" : "R4 clear alias"), rd, m_ctrl);
        end
      end
    end

    // R5 soft reset wipes fields, then releasing it keeps them clear
    bus_write(5'h00, 32'h0011_F37F); m_ctrl = model_next(0, m_ctrl, 32'h0011_F37F);
    bus_write(5'h04, 32'h8000_0000); m_ctrl = model_next(1, m_ctrl, 32'h8000_0000);
    bus_read(5'h00, rd); check("R5 soft reset clears fields", rd, 32'h8000_0000);
    bus_write(5'h04, 32'h0000_0001); // ignored while held
    bus_write(5'h08, 32'h8000_0000); m_ctrl = 32'h0;
    bus_read(5'h00, rd); check("R5 held write ignored", rd, m_ctrl);

    // R11 alias reads and unmapped offset
    bus_write(5'h00, 32'h0000_5321); m_ctrl = model_next(0, m_ctrl, 32'h0000_5321);
    bus_read(5'h04, rd); check("R11 set alias read", rd, m_ctrl);
    bus_read(5'h08, rd); check("R11 clear alias read", rd, m_ctrl);
    bus_read(5'h0C, rd); check("R11 offset C reads zero", rd, 32'h0);
    bus_write(5'h0C, 32'hFFFF_FFFF);
    bus_read(5'h00, rd); check("R11 offset C write ignored", rd, m_ctrl);
    bus_write(5'h1C, 32'hFFFF_FFFF);
    bus_read(5'h1C, rd); check("R11 status offset C reads zero", rd, 32'h0);

    // R12 read returns value before a same-edge write
    @(negedge clk);
    bus_addr = 5'h00; bus_we = 1'b1; bus_wdata = 32'h0000_0002;
    @(negedge clk);
    bus_we = 1'b0;
    check("R12 read sees old word", bus_rdata, m_ctrl);
    m_ctrl = model_next(0, m_ctrl, 32'h0000_0002);
    @(negedge clk);
    check("R12 next read sees new word", bus_rdata, m_ctrl);

    // R7 R8 busy and flags
    hw_busy = 1'b1;
    bus_read(5'h10, rd); check("R7 busy shown", rd, stat_exp());
    bus_write(5'h10, 32'h0000_0031);
    bus_write(5'h14, 32'h0000_0031);
    bus_write(5'h18, 32'h0000_0001);
    bus_read(5'h14, rd); check("R8 software cannot set flags", rd, stat_exp());
    hw_busy = 1'b0;
    pulse(1'b1, 1'b0);
    bus_read(5'h10, rd); check("R7 underflow sticky", rd, stat_exp());
    pulse(1'b0, 1'b1);
    bus_write(5'h10, 32'h0);
    bus_read(5'h18, rd); check("R8 plain write keeps flags", rd, stat_exp());
    bus_write(5'h18, 32'h0000_0010); m_uf = 1'b0;
    bus_read(5'h10, rd); check("R7 clear underflow only", rd, stat_exp());
    bus_write(5'h18, 32'h0000_0020); m_of = 1'b0;
    bus_read(5'h10, rd); check("R7 clear overflow", rd, stat_exp());

    // R9 event races its clear
    @(negedge clk);
    evt_underflow = 1'b1; bus_addr = 5'h18; bus_we = 1'b1; bus_wdata = 32'h10;
    @(negedge clk);
    evt_underflow = 1'b0; bus_we = 1'b0; m_uf = 1'b1;
    bus_read(5'h10, rd); check("R9 event beats clear", rd, stat_exp());
    bus_write(5'h18, 32'h30); m_uf = 1'b0;

    // R10 interrupt
    bus_write(5'h04, 32'h0010_0000); m_ctrl = model_next(1, m_ctrl, 32'h0010_0000);
    check("R10 no irq without flag", {31'b0, irq}, 32'h0);
    pulse(1'b0, 1'b1);
    @(negedge clk);
    check("R10 irq on overflow", {31'b0, irq}, 32'h1);
    bus_write(5'h08, 32'h0010_0000); m_ctrl = model_next(2, m_ctrl, 32'h0010_0000);
    @(negedge clk);
    check("R10 irq masked by enable", {31'b0, irq}, 32'h0);
    bus_write(5'h04, 32'h0010_0000);
    @(negedge clk);
    check("R10 irq re-enabled", {31'b0, irq}, 32'h1);
    bus_write(5'h18, 32'h20); m_of = 1'b0;
    @(negedge clk);
    check("R10 irq drops after clear", {31'b0, irq}, 32'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule